// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs single Clause 22 management transactions between a MAC-side controller and an Ethernet PHY over the two-wire MDC/MDIO management bus. Software, or a small host-side state machine, composes one 32-bit management word holding every field of the frame. A single strobed write of that word launches the transfer. The block sends a fixed run of preamble ones and then the word itself, most significant bit first, on a management clock derived from the system clock. It then reports completion through an idle flag.

For a read, the block stops driving the data line at the turnaround and shifts in the 16 bits that the PHY returns. It writes them back into the data field of the same word, so software polls idle and then reads one register. Launches are accepted only while the management enable input is high and the block is idle. The MDC rate is picked from six divide ratios through a small select input and held for the whole frame.

Top module: `mdio_frame_ctrl`

## Requirements
- R1: When `frame_wr` is high while `mgmt_en` is high and `idle` is high, the word on `frame_wdata` is accepted at that clock edge. From the next cycle `idle` is 0 and `frame_rdata` holds the written word.
- R2: While `mgmt_en` is low, `frame_wr` has no effect: `idle` stays 1, `mdc` stays low and `frame_rdata` keeps its value.
- R3: A transaction puts exactly 64 bits on `mdio_o`, one for each MDC rising edge. The first 32 are ones; the rest are word bits 31 down to 0. The word is sent as written, and its layout is: [31:30] start (01), [29:28] operation (01 write, 10 read), [27:23] PHY address, [22:18] register address, [17:16] turnaround (10), [15:0] data.
- R4: `mdio_o` and `mdio_oe` change only when MDC falls, never on its rising edge. While idle, `mdc` is low and `mdio_oe` is low.
- R5: For a read (operation field 10), `mdio_oe` is high for the preamble and the first 14 frame bits. It is low from the first turnaround bit (word bit 17) through word bit 0. For any other operation code, `mdio_oe` is high for all 64 bits.
- R6: During a read, `mdio_i` is sampled at the MDC rising edges of the 16 data bits, most significant first. When `idle` returns to 1, the result is in `frame_rdata[15:0]`, and bits [31:16] keep the written values.
- R7: A read with `mdio_i` held high for the whole frame, as from an absent PHY with a pull-up, returns 0xFFFF in `frame_rdata[15:0]`.
- R8: `div_sel` is captured at launch and sets the MDC period in system clocks: 0→8, 1→16, 2→32, 3→48, 4→64, 5→96, and 6 or 7→96. MDC is low for the first half of each period and high for the second. `idle` stays low for exactly 64 periods.
- R9: A `frame_wr` that arrives while a transaction is in progress is ignored. The frame on the wire and the final `frame_rdata` match the first word.
- R10: At the end of a write transaction, `frame_rdata` still equals the word that was written.
- R11: While `rst` is asserted, `idle` is 1, `mdc` is 0, `mdio_oe` is 0, `mdio_o` is 1 and `frame_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_en | input | 1 | Management port enable; launches are accepted only while high |
| frame_wr | input | 1 | Write strobe for the management word |
| frame_wdata | input | 32 | Management word to launch |
| div_sel | input | 3 | MDC divide ratio select |
| frame_rdata | output | 32 | Current management word; read data is placed in bits [15:0] |
| idle | output | 1 | 1 when no transaction is in progress |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for `mdio_o`; low releases the line |
| mdio_i | input | 1 | Management data returned from the line |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble and a 7-bit divider counter. At these values the longest frame, at ratio 96, lasts 6144 system clocks, so every one of the eight `div_sel` codes can be reached, including the two codes that clamp to 96. Random reads and writes at random ratios fit in the run next to directed cases: a frame attempted while disabled, a write arriving mid-frame, and a read from a line held high. A behavioural PHY in the bench records the data line at each MDC rise and returns read data on MDC falls.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;

    localparam int FRAME_W   = 32;
    localparam int DATA_W    = 16;
    localparam int CNT_W     = 7;
    localparam int DIV_SEL_W = 3;
    // frame bits that precede the turnaround field
    localparam int TA_OFS    = FRAME_W - DATA_W - 2;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef struct packed {
        logic [1:0]        sof;
        logic [1:0]        op;
        logic [4:0]        phy;
        logic [4:0]        regad;
        logic [1:0]        ta;
        logic [DATA_W-1:0] data;
    } mgmt_word_t;

    function automatic logic [CNT_W-1:0] mdc_ratio(input logic [DIV_SEL_W-1:0] sel);
        case (sel)
            3'd0:    mdc_ratio = 7'd8;
            3'd1:    mdc_ratio = 7'd16;
            3'd2:    mdc_ratio = 7'd32;
            3'd3:    mdc_ratio = 7'd48;
            3'd4:    mdc_ratio = 7'd64;
            default: mdc_ratio = 7'd96;
        endcase
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_frame_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] ratio,
    output logic             mdc,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] full_m1;

    assign half_m1  = (ratio >> 1) - 1'b1;
    assign full_m1  = ratio - 1'b1;
    assign rise_evt = run && (cnt == half_m1);
    assign fall_evt = run && (cnt == full_m1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            if (fall_evt) cnt <= '0;
            else          cnt <= cnt + 1'b1;
            if (rise_evt)      mdc <= 1'b1;
            else if (fall_evt) mdc <= 1'b0;
        end
    end

endmodule

// File: rtl/mdio_bit_seq.sv
module mdio_bit_seq
    import mdio_frame_pkg::*;
#(
    parameter  int PRE_LEN = 32,
    localparam int TOTAL   = PRE_LEN + FRAME_W,
    localparam int IDX_W   = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mgmt_word_t        word,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              mdio_i,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);

    logic [IDX_W-1:0]   idx;
    logic [IDX_W-1:0]   nxt_idx;
    logic [FRAME_W-1:0] wbits;
    logic               nxt_bit;
    logic               nxt_oe;
    logic               is_read;
    logic               last;
    int                 fpos;

    assign wbits   = word;
    assign is_read = (word.op == OP_READ);
    assign last    = (int'(idx) == TOTAL - 1);
    assign done    = busy && fall_evt && last;

    always_comb begin
        nxt_idx = idx + 1'b1;
        fpos    = TOTAL - 1 - int'(nxt_idx);
        if (int'(nxt_idx) < PRE_LEN) nxt_bit = 1'b1;
        else                         nxt_bit = wbits[fpos[4:0]];
        nxt_oe  = !(is_read && (int'(nxt_idx) >= PRE_LEN + TA_OFS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            idx     <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rd_data <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            idx     <= '0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b1;
        end else if (busy) begin
            if (rise_evt && (int'(idx) >= TOTAL - DATA_W))
                rd_data <= {rd_data[DATA_W-2:0], mdio_i};
            if (fall_evt) begin
                if (last) begin
                    busy    <= 1'b0;
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b1;
                end else begin
                    idx     <= nxt_idx;
                    mdio_o  <= nxt_bit;
                    mdio_oe <= nxt_oe;
                end
            end
        end
    end

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_frame_pkg::*;
#(
    parameter int PREAMBLE_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mgmt_en,
    input  logic                 frame_wr,
    input  logic [FRAME_W-1:0]   frame_wdata,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic [FRAME_W-1:0]   frame_rdata,
    output logic                 idle,
    output logic                 mdc,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    input  logic                 mdio_i
);

    mgmt_word_t        word_q;
    logic [CNT_W-1:0]  ratio_q;
    logic [DATA_W-1:0] rd_data;
    logic              busy;
    logic              done;
    logic              accept;
    logic              rise_evt;
    logic              fall_evt;

    assign accept = frame_wr && mgmt_en && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            ratio_q <= 7'd8;
        end else if (accept) begin
            word_q  <= frame_wdata;
            ratio_q <= mdc_ratio(div_sel);
        end else if (done && (word_q.op == OP_READ)) begin
            word_q.data <= rd_data;
        end
    end

    mdio_mdc_gen u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .ratio    (ratio_q),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_bit_seq #(.PRE_LEN(PREAMBLE_LEN)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .word     (word_q),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .done     (done),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data)
    );

    assign frame_rdata = word_q;
    assign idle        = !busy;

endmodule

// File: rtl/mdio_frame_ctrl_chk.sv
module mdio_frame_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        mgmt_en,
    input logic        frame_wr,
    input logic [31:0] frame_wdata,
    input logic [31:0] frame_rdata,
    input logic        idle,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);

    assert_launch_R1: assert property (@(posedge clk) disable iff (rst)
        (idle && mgmt_en && frame_wr) |=> (!idle && frame_rdata == $past(frame_wdata)));

    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (idle && !mgmt_en) |=> idle);

    assert_stable_at_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    assert_idle_pins_R4: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!mdc && !mdio_oe));

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!idle && frame_wr) |=> (idle || $stable(frame_rdata)));

endmodule

bind mdio_frame_ctrl mdio_frame_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .mgmt_en     (mgmt_en),
    .frame_wr    (frame_wr),
    .frame_wdata (frame_wdata),
    .frame_rdata (frame_rdata),
    .idle        (idle),
    .mdc         (mdc),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe)
);

// File: tb/mdio_frame_ctrl_bench.sv
module mdio_frame_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst;
    logic        mgmt_en;
    logic        frame_wr;
    logic [31:0] frame_wdata;
    logic [2:0]  div_sel;
    logic [31:0] frame_rdata;
    logic        idle;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    mdio_frame_ctrl u_mdio_frame_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mgmt_en     (mgmt_en),
        .frame_wr    (frame_wr),
        .frame_wdata (frame_wdata),
        .div_sel     (div_sel),
        .frame_rdata (frame_rdata),
        .idle        (idle),
        .mdc         (mdc),
        .mdio_o      (mdio_o),
        .mdio_oe     (mdio_oe),
        .mdio_i      (mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural PHY: records the line at MDC rise, answers at MDC fall
    int          rise_cnt = 0;
    int          base     = 0;
    logic [63:0] cap_o    = '0;
    logic [63:0] cap_oe   = '0;
    logic [15:0] phy_rd   = '0;

    always @(posedge mdc) begin
        int n;
        n = rise_cnt - base;
        if (n >= 0 && n < 64) begin
            cap_o[63-n]  = mdio_o;
            cap_oe[63-n] = mdio_oe;
        end
        rise_cnt = rise_cnt + 1;
    end

    always @(negedge mdc) begin
        int n;
        n = rise_cnt - base;
        if (n >= 48 && n < 64) mdio_i = phy_rd[63-n];
        else                   mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_ratio(input logic [2:0] sel);
        case (sel)
            3'd0: return 8;
            3'd1: return 16;
            3'd2: return 32;
            3'd3: return 48;
            3'd4: return 64;
            default: return 96;
        endcase
    endfunction

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] rg, input logic [15:0] d);
        return {2'b01, op, phy, rg, 2'b10, d};
    endfunction

    function automatic logic [63:0] exp_oe(input logic [31:0] w);
        if (w[29:28] == 2'b10) return {32'hFFFF_FFFF, 14'h3FFF, 18'h0};
        return 64'hFFFF_FFFF_FFFF_FFFF;
    endfunction

    task automatic run_frame(input logic [31:0] word, input logic [2:0] sel,
                             input logic [15:0] rd, input bit inject);
        int          cyc;
        bit          is_rd;
        logic [31:0] exp_word;
        is_rd  = (word[29:28] == 2'b10);
        phy_rd = rd;
        base   = rise_cnt;
        div_sel     = sel;
        frame_wdata = word;
        frame_wr    = 1'b1;
        @(negedge clk);
        frame_wr = 1'b0;
        chk(idle == 1'b0, "R1 idle after launch", 64'(idle), 64'd0);
        chk(frame_rdata == word, "R1 word latched", 64'(frame_rdata), 64'(word));
        cyc = 0;
        while (idle == 1'b0 && cyc < 7000) begin
            cyc++;
            if (inject && cyc == 20) begin
                frame_wdata = ~word;
                frame_wr    = 1'b1;
            end
            if (inject && cyc == 21) frame_wr = 1'b0;
            @(negedge clk);
        end
        chk(cyc == 64 * exp_ratio(sel), "R8 frame duration", 64'(cyc), 64'(64 * exp_ratio(sel)));
        chk(rise_cnt - base == 64, "R3 MDC rise count", 64'(rise_cnt - base), 64'd64);
        chk(cap_o == {32'hFFFF_FFFF, word}, inject ? "R9 R3 bits on wire" : "R3 bits on wire",
            cap_o, {32'hFFFF_FFFF, word});
        chk(cap_oe == exp_oe(word), is_rd ? "R5 read release" : "R5 write drive",
            cap_oe, exp_oe(word));
        exp_word = is_rd ? {word[31:16], rd} : word;
        chk(frame_rdata == exp_word,
            inject ? "R9 result of first word" : (is_rd ? "R6 read data" : "R10 write word kept"),
            64'(frame_rdata), 64'(exp_word));
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R4 idle pins", {62'd0, mdc, mdio_oe}, 64'd0);
        @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit dis_ok;
        void'($urandom(32'd1234));
        rst = 1'b1; mgmt_en = 1'b0; frame_wr = 1'b0; frame_wdata = '0; div_sel = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b1,
            "R11 reset pins", {60'd0, idle, mdc, mdio_oe, mdio_o}, 64'b1001);
        chk(frame_rdata == 32'd0, "R11 reset word", 64'(frame_rdata), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R2 disabled port ignores writes
        frame_wdata = mk(2'b01, 5'h03, 5'h00, 16'hA5A5);
        frame_wr = 1'b1;
        @(negedge clk);
        frame_wr = 1'b0;
        dis_ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (!(idle == 1'b1 && mdc == 1'b0)) dis_ok = 1'b0;
            @(negedge clk);
        end
        chk(dis_ok, "R2 idle while disabled", 64'(dis_ok), 64'd1);
        chk(frame_rdata == 32'd0, "R2 word unchanged", 64'(frame_rdata), 64'd0);
        mgmt_en = 1'b1;

        // directed frames
        run_frame(mk(2'b01, 5'h11, 5'h04, 16'hBEEF), 3'd0, 16'h0000, 1'b0); // R10 write
        run_frame(mk(2'b10, 5'h01, 5'h02, 16'h0000), 3'd1, 16'h1234, 1'b0); // R6 read
        run_frame(mk(2'b10, 5'h1F, 5'h03, 16'h5555), 3'd2, 16'hFFFF, 1'b0); // R7 absent PHY
        chk(frame_rdata[15:0] == 16'hFFFF, "R7 absent PHY", 64'(frame_rdata[15:0]), 64'hFFFF);
        run_frame(mk(2'b10, 5'h02, 5'h1E, 16'h0F0F), 3'd0, 16'h8001, 1'b1); // R9 mid-frame write
        run_frame(mk(2'b01, 5'h05, 5'h09, 16'h0001), 3'd3, 16'h0000, 1'b0); // R8 ratio 48
        run_frame(mk(2'b01, 5'h06, 5'h0A, 16'h8000), 3'd6, 16'h0000, 1'b0); // R8 clamp
        run_frame(mk(2'b10, 5'h07, 5'h0B, 16'h0000), 3'd7, 16'h00FF, 1'b0); // R8 clamp

        // random frames
        for (int k = 0; k < 10; k++) begin
            logic [1:0]  op;
            logic [31:0] w;
            op = ($urandom % 2) ? 2'b10 : 2'b01;
            w  = mk(op, 5'($urandom), 5'($urandom), 16'($urandom));
            run_frame(w, 3'($urandom % 8), 16'($urandom), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule